// File: doc/BRIEF.md
# Address-Space-Tagged Virtual Instruction Cache

This block is a direct-mapped, read-only instruction cache that is both indexed and tagged with virtual addresses. Each stored line also records the address space identifier (ASID) that was current when the line was filled. A lookup hits only when the virtual tag matches and either the stored ASID equals the ASID presented with the fetch or the line is marked global. As a result, one virtual address used by two address spaces never returns the other space's instructions.

A fetch that misses raises one refill request for the whole line. When the line comes back, it is written into the cache, and in the same cycle the requested word is handed to the fetch side. Maintenance has two forms. The first is an ASID invalidate, used before an identifier is recycled: it walks every set, one per cycle, and drops the non-global lines owned by that ASID. The second is a single-cycle invalidate-all. Two copies of one physical line held under different virtual addresses are legal, and the cache does nothing to find them.

The fetch address is a word address. With the default parameters it is split as follows: the word offset is bits [1:0], the set index is bits [5:2], and the tag is bits [15:6].

Top module: `asid_icache`

## Requirements
- R1: After reset every line is invalid, `ready` is 1, and `busy`, `refill_req` and `fetch_valid` are 0.
- R2: A fetch accepted while `ready` is 1 hits a valid line with a matching tag and matching ASID. One cycle after acceptance it returns the word at the fetch's offset on `fetch_data` with `fetch_valid` high, and it raises no refill.
- R3: On a miss, `refill_req` rises in the cycle after acceptance. It carries `refill_addr` = fetch address with the offset bits removed and stays high until `refill_ack`. In the `refill_ack` cycle, `fetch_valid` is high with the requested word taken from `refill_data`, where word w sits at bits [w*WORD_W +: WORD_W]. The line is then stored with the ASID of the fetch.
- R4: A non-global line filled under one ASID misses when the same virtual address is fetched with a different ASID.
- R5: A line filled with `refill_global` = 1 hits for any ASID.
- R6: An accepted ASID invalidate keeps `busy` high and `ready` low for exactly SETS cycles. Afterwards, non-global lines of that ASID miss, while lines of other ASIDs and global lines still hit.
- R7: An accepted invalidate-all takes effect in one cycle. It never raises `busy`, and every line misses afterwards, global ones included.
- R8: When several requests arrive in one cycle, invalidate-all beats ASID invalidate, which beats fetch. The losers are dropped and produce no response.
- R9: Two addresses with equal index bits and different tag bits displace each other in the single line of that set.
- R10: While `ready` is 0, fetch requests are ignored. They produce neither `fetch_valid` nor a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request |
| fetch_va | input | VA_W | Virtual word address of the fetch |
| fetch_asid | input | ASID_W | ASID current for the fetch |
| ready | output | 1 | Requests are accepted in this cycle |
| fetch_valid | output | 1 | Fetch result valid |
| fetch_data | output | WORD_W | Fetched instruction word |
| refill_req | output | 1 | Line refill request |
| refill_addr | output | VA_W-OFF_W | Line address of the refill |
| refill_ack | input | 1 | Refill line present on `refill_data` |
| refill_data | input | LINE_WORDS*WORD_W | Returned line |
| refill_global | input | 1 | Returned line is shared by all address spaces |
| inv_asid_req | input | 1 | Invalidate lines of one ASID |
| inv_asid_id | input | ASID_W | ASID to invalidate |
| inv_all_req | input | 1 | Invalidate every line |
| busy | output | 1 | ASID invalidate walk running |

## Verification
The bench targets homonyms. It fetches the same virtual address under a second ASID, and a design that ignored the ASID in its compare would return the first space's word. It also checks that a global line survives both a foreign-ASID lookup and an ASID invalidate. A design that cleared global lines during the walk, or that cut the walk short or ran it too long, shows up as wrong hit/miss results or a wrong `busy` length. The bench also issues requests together to test the priority order, and issues fetches during a walk. A design that let a fetch slip past an invalidate would raise a refill or a response where none is allowed.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_WALK = 2'd2
  } ic_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 10,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic              clr_all,
  input  logic              walk_en,
  input  logic [IDX_W-1:0]  walk_idx,
  input  logic [ASID_W-1:0] walk_asid,
  output logic [SETS-1:0]   valid_vec
);
  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   glb_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [ASID_W-1:0] asid_q [SETS];
  logic              walk_kill;

  // Hit rule: valid, same tag, and either shared or owned by the caller.
  function automatic logic entry_match(input logic v, input logic g,
                                       input logic [TAG_W-1:0] st,
                                       input logic [ASID_W-1:0] sa,
                                       input logic [TAG_W-1:0] lt,
                                       input logic [ASID_W-1:0] la);
    return v && (st == lt) && (g || (sa == la));
  endfunction

  // Walk drops a line only if it is private and owned by the target.
  function automatic logic owned_private(input logic v, input logic g,
                                         input logic [ASID_W-1:0] sa,
                                         input logic [ASID_W-1:0] ta);
    return v && !g && (sa == ta);
  endfunction

  assign lk_hit    = entry_match(vld_q[lk_idx], glb_q[lk_idx], tag_q[lk_idx],
                                 asid_q[lk_idx], lk_tag, lk_asid);
  assign walk_kill = walk_en && owned_private(vld_q[walk_idx], glb_q[walk_idx],
                                              asid_q[walk_idx], walk_asid);
  assign valid_vec = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      glb_q <= '0;
    end else if (clr_all) begin
      vld_q <= '0;
    end else begin
      if (walk_kill) vld_q[walk_idx] <= 1'b0;
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        glb_q[wr_idx] <= wr_glob;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      asid_q[wr_idx] <= wr_asid;
    end
  end
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int SETS       = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int LINE_W = LINE_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] mem_q [SETS];
  logic [LINE_W-1:0] rd_line;

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] ln,
                                                input logic [OFF_W-1:0] off);
    return ln[off*WORD_W +: WORD_W];
  endfunction

  assign rd_line = mem_q[rd_idx];
  assign rd_word = word_of(rd_line, rd_off);

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_line;
  end
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic              inv_all_req,
  input  logic              inv_asid_req,
  input  logic [ASID_W-1:0] inv_asid_id,
  input  logic              lk_hit,
  input  logic              refill_ack,
  output logic              ready,
  output logic              busy,
  output logic              acc_fetch,
  output logic              acc_all,
  output logic              acc_asid,
  output logic              in_miss,
  output logic              walk_en,
  output logic [IDX_W-1:0]  walk_idx,
  output logic [ASID_W-1:0] walk_asid
);
  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

  ic_state_e         state_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [ASID_W-1:0] tgt_q;

  // Fixed priority: invalidate-all, then ASID invalidate, then fetch.
  assign ready     = (state_q == ST_IDLE);
  assign acc_all   = ready && inv_all_req;
  assign acc_asid  = ready && !inv_all_req && inv_asid_req;
  assign acc_fetch = ready && !inv_all_req && !inv_asid_req && fetch_req;
  assign in_miss   = (state_q == ST_MISS);
  assign walk_en   = (state_q == ST_WALK);
  assign busy      = walk_en;
  assign walk_idx  = cnt_q;
  assign walk_asid = tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc_asid) begin
            state_q <= ST_WALK;
            cnt_q   <= '0;
            tgt_q   <= inv_asid_id;
          end else if (acc_fetch && !lk_hit) begin
            state_q <= ST_MISS;
          end
        end
        ST_MISS: if (refill_ack) state_q <= ST_IDLE;
        ST_WALK: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_SET) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asid_icache.sv
module asid_icache
  import icache_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16,
  parameter int ASID_W     = 8,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = VA_W - IDX_W - OFF_W,
  localparam int LINE_W = LINE_WORDS * WORD_W,
  localparam int LA_W   = VA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [VA_W-1:0]   fetch_va,
  input  logic [ASID_W-1:0] fetch_asid,
  output logic              ready,
  output logic              fetch_valid,
  output logic [WORD_W-1:0] fetch_data,
  output logic              refill_req,
  output logic [LA_W-1:0]   refill_addr,
  input  logic              refill_ack,
  input  logic [LINE_W-1:0] refill_data,
  input  logic              refill_global,
  input  logic              inv_asid_req,
  input  logic [ASID_W-1:0] inv_asid_id,
  input  logic              inv_all_req,
  output logic              busy
);
  function automatic logic [OFF_W-1:0] va_off(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] va_idx(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] va_tag(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: TAG_W];
  endfunction
  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                  input logic [OFF_W-1:0] off);
    return ln[off*WORD_W +: WORD_W];
  endfunction

  logic              lk_hit;
  logic              acc_fetch, acc_all, acc_asid;
  logic              in_miss, walk_en;
  logic [IDX_W-1:0]  walk_idx;
  logic [ASID_W-1:0] walk_asid;
  logic [SETS-1:0]   valid_vec;
  logic [WORD_W-1:0] rd_word;
  logic              refill_done;
  logic              hit_accept;
  logic [VA_W-1:0]   miss_va_q;
  logic [ASID_W-1:0] miss_asid_q;
  logic              hit_q;
  logic [WORD_W-1:0] hit_data_q;

  assign refill_done = in_miss && refill_ack;
  assign hit_accept  = acc_fetch && lk_hit;

  icache_ctrl #(.SETS(SETS), .ASID_W(ASID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .inv_all_req(inv_all_req),
    .inv_asid_req(inv_asid_req), .inv_asid_id(inv_asid_id),
    .lk_hit(lk_hit), .refill_ack(refill_ack),
    .ready(ready), .busy(busy),
    .acc_fetch(acc_fetch), .acc_all(acc_all), .acc_asid(acc_asid),
    .in_miss(in_miss), .walk_en(walk_en),
    .walk_idx(walk_idx), .walk_asid(walk_asid)
  );

  icache_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(va_idx(fetch_va)), .lk_tag(va_tag(fetch_va)),
    .lk_asid(fetch_asid), .lk_hit(lk_hit),
    .wr_en(refill_done), .wr_idx(va_idx(miss_va_q)),
    .wr_tag(va_tag(miss_va_q)), .wr_asid(miss_asid_q),
    .wr_glob(refill_global),
    .clr_all(acc_all),
    .walk_en(walk_en), .walk_idx(walk_idx), .walk_asid(walk_asid),
    .valid_vec(valid_vec)
  );

  icache_data_store #(.SETS(SETS), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk(clk),
    .rd_idx(va_idx(fetch_va)), .rd_off(va_off(fetch_va)), .rd_word(rd_word),
    .wr_en(refill_done), .wr_idx(va_idx(miss_va_q)), .wr_line(refill_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_va_q   <= '0;
      miss_asid_q <= '0;
      hit_q       <= 1'b0;
      hit_data_q  <= '0;
    end else begin
      hit_q <= hit_accept;
      if (hit_accept) hit_data_q <= rd_word;
      if (acc_fetch && !lk_hit) begin
        miss_va_q   <= fetch_va;
        miss_asid_q <= fetch_asid;
      end
    end
  end

  assign refill_req  = in_miss;
  assign refill_addr = miss_va_q[VA_W-1:OFF_W];
  assign fetch_valid = hit_q || refill_done;
  assign fetch_data  = refill_done ? pick_word(refill_data, va_off(miss_va_q))
                                   : hit_data_q;
endmodule

// File: rtl/icache_checker.sv
module icache_checker #(
  parameter int SETS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            busy,
  input logic            refill_req,
  input logic            refill_ack,
  input logic            fetch_valid,
  input logic            acc_fetch,
  input logic            acc_all,
  input logic [SETS-1:0] valid_vec
);
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= '0;
  end

  // R10: no request can be accepted during a walk.
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);

  // R3: the refill request stays up until it is answered.
  a_r3_refill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_ack) |=> refill_req);

  // R3: no refill request while idle.
  a_r3_no_refill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !refill_req);

  // R2: every response follows an accepted fetch or a completed refill.
  a_r2_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> ($past(acc_fetch) || (refill_req && refill_ack)));

  // R7: invalidate-all empties the cache in one cycle.
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    acc_all |=> (valid_vec == '0));

  // R7: invalidate-all never starts a walk.
  a_r7_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_all |=> !busy);

  // R6: a walk lasts exactly one cycle per set.
  a_r6_walk_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == SETS));
endmodule

bind asid_icache icache_checker #(.SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .busy(busy),
  .refill_req(refill_req), .refill_ack(refill_ack),
  .fetch_valid(fetch_valid), .acc_fetch(acc_fetch), .acc_all(acc_all),
  .valid_vec(valid_vec)
);

// File: tb/asid_icache_tb.sv
module asid_icache_tb;
  localparam int VA_W = 16, WORD_W = 32, LW = 4, SETS = 16, ASID_W = 8;
  localparam int LA_W = VA_W - 2;

  typedef struct packed {
    logic [9:0] tg;
    logic [3:0] ix;
    logic [1:0] of;
    logic [7:0] as;
    logic       gl;
    logic       hit;
    logic [7:0] fas;
  } vec_t;

  // tag, index, offset, asid, global-on-fill, expect hit, asid of stored line
  localparam vec_t VEC [12] = '{
    '{10'd1, 4'd2,  2'd0, 8'd5, 1'b0, 1'b0, 8'd5},  // R3 cold miss
    '{10'd1, 4'd2,  2'd3, 8'd5, 1'b0, 1'b1, 8'd5},  // R2 hit
    '{10'd1, 4'd2,  2'd1, 8'd6, 1'b0, 1'b0, 8'd6},  // R4 homonym miss
    '{10'd1, 4'd2,  2'd2, 8'd5, 1'b0, 1'b0, 8'd5},  // R4 back again
    '{10'd3, 4'd7,  2'd0, 8'd9, 1'b1, 1'b0, 8'd9},  // R5 global fill
    '{10'd3, 4'd7,  2'd2, 8'd4, 1'b0, 1'b1, 8'd9},  // R5 global hit
    '{10'd2, 4'd2,  2'd0, 8'd5, 1'b0, 1'b0, 8'd5},  // R9 conflict
    '{10'd1, 4'd2,  2'd0, 8'd5, 1'b0, 1'b0, 8'd5},  // R9 evicted
    '{10'd0, 4'd0,  2'd3, 8'd5, 1'b0, 1'b0, 8'd5},  // R3
    '{10'd0, 4'd0,  2'd1, 8'd5, 1'b0, 1'b1, 8'd5},  // R2
    '{10'd4, 4'd15, 2'd0, 8'd7, 1'b0, 1'b0, 8'd7},  // R3
    '{10'd4, 4'd15, 2'd3, 8'd7, 1'b0, 1'b1, 8'd7}   // R2
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fetch_req = 1'b0;
  logic [VA_W-1:0]   fetch_va = '0;
  logic [ASID_W-1:0] fetch_asid = '0;
  logic              ready, fetch_valid, refill_req, busy;
  logic [WORD_W-1:0] fetch_data;
  logic [LA_W-1:0]   refill_addr;
  logic              refill_ack = 1'b0;
  logic [LW*WORD_W-1:0] refill_data = '0;
  logic              refill_global = 1'b0;
  logic              inv_asid_req = 1'b0;
  logic [ASID_W-1:0] inv_asid_id = '0;
  logic              inv_all_req = 1'b0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  asid_icache #(.VA_W(VA_W), .WORD_W(WORD_W), .LINE_WORDS(LW), .SETS(SETS),
                .ASID_W(ASID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_va(fetch_va),
    .fetch_asid(fetch_asid), .ready(ready), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .refill_req(refill_req), .refill_addr(refill_addr),
    .refill_ack(refill_ack), .refill_data(refill_data),
    .refill_global(refill_global), .inv_asid_req(inv_asid_req),
    .inv_asid_id(inv_asid_id), .inv_all_req(inv_all_req), .busy(busy)
  );

  // Bench's own word pattern: fill ASID, marker, line address, word number.
  function automatic logic [WORD_W-1:0] gen(input logic [LA_W-1:0] la,
                                            input logic [1:0] w,
                                            input logic [7:0] as);
    return {as, 8'hC0, la, w};
  endfunction

  function automatic logic [LW*WORD_W-1:0] mkline(input logic [LA_W-1:0] la,
                                                  input logic [7:0] as);
    logic [LW*WORD_W-1:0] l;
    for (int w = 0; w < LW; w++) l[w*WORD_W +: WORD_W] = gen(la, 2'(w), as);
    return l;
  endfunction

  task automatic check(input bit ok, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [9:0] tg, input logic [3:0] ix,
                          input logic [1:0] of, input logic [7:0] as,
                          input bit gl, input bit exph, input logic [7:0] fas,
                          input string rq);
    logic [VA_W-1:0] va;
    va = {tg, ix, of};
    @(negedge clk);
    check(ready == 1'b1, {rq, " ready"}, 64'(ready), 64'd1);
    fetch_req = 1'b1; fetch_va = va; fetch_asid = as;
    @(negedge clk);
    fetch_req = 1'b0;
    if (exph) begin
      check(fetch_valid && !refill_req && fetch_data == gen(va[15:2], of, fas),
            {rq, " hit data"}, {31'd0, fetch_valid, fetch_data},
            {32'd1, gen(va[15:2], of, fas)});
    end else begin
      check(!fetch_valid && refill_req && refill_addr == va[15:2],
            {rq, " miss request"}, {fetch_valid, refill_req, 48'd0, refill_addr},
            {2'b01, 48'd0, va[15:2]});
      @(negedge clk);
      check(refill_req && !fetch_valid, "R3 refill held", 64'(refill_req), 64'd1);
      refill_ack = 1'b1; refill_data = mkline(va[15:2], fas); refill_global = gl;
      #1;
      check(fetch_valid && fetch_data == gen(va[15:2], of, fas),
            {rq, " refill word"}, {31'd0, fetch_valid, fetch_data},
            {32'd1, gen(va[15:2], of, fas)});
      @(negedge clk);
      refill_ack = 1'b0; refill_global = 1'b0;
    end
  endtask

  // R6 / R10: runs an ASID invalidate with a fetch held high throughout.
  task automatic do_inv(input logic [7:0] id);
    int n;
    bit quiet;
    n = 0; quiet = 1'b1;
    @(negedge clk);
    inv_asid_req = 1'b1; inv_asid_id = id;
    @(negedge clk);
    inv_asid_req = 1'b0;
    fetch_req = 1'b1; fetch_va = 16'hFFFF; fetch_asid = 8'd3;
    while (busy && n < 100) begin
      if (ready || refill_req || fetch_valid) quiet = 1'b0;
      n++;
      @(negedge clk);
    end
    fetch_req = 1'b0;
    check(n == SETS, "R6 busy length", 64'(n), 64'(SETS));
    check(quiet && !refill_req, "R10 fetch ignored while busy",
          {62'd0, quiet, refill_req}, 64'd2);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=50000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready && !busy && !refill_req && !fetch_valid, "R1 reset outputs",
          {ready, busy, refill_req, fetch_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !busy && !refill_req && !fetch_valid, "R1 after reset",
          {ready, busy, refill_req, fetch_valid}, 4'b1000);

    foreach (VEC[i]) begin
      do_fetch(VEC[i].tg, VEC[i].ix, VEC[i].of, VEC[i].as, VEC[i].gl,
               VEC[i].hit, VEC[i].fas, $sformatf("vec%0d", i));
    end

    // R6: drop ASID 5; ASID 7 and the global line survive.
    do_inv(8'd5);
    do_fetch(10'd0, 4'd0, 2'd2, 8'd5, 1'b0, 1'b0, 8'd5, "R6 owner line gone");
    do_fetch(10'd4, 4'd15, 2'd1, 8'd7, 1'b0, 1'b1, 8'd7, "R6 other asid kept");
    do_fetch(10'd3, 4'd7, 2'd1, 8'd2, 1'b0, 1'b1, 8'd9, "R6 global kept");
    // R6: invalidating the global line's fill ASID leaves it in place.
    do_inv(8'd9);
    do_fetch(10'd3, 4'd7, 2'd3, 8'd1, 1'b0, 1'b1, 8'd9, "R6 global survives own asid");

    // R8: ASID invalidate beats fetch.
    @(negedge clk);
    inv_asid_req = 1'b1; inv_asid_id = 8'd7;
    fetch_req = 1'b1; fetch_va = 16'h1234; fetch_asid = 8'd7;
    @(negedge clk);
    inv_asid_req = 1'b0; fetch_req = 1'b0;
    check(busy && !fetch_valid && !refill_req, "R8 asid over fetch",
          {busy, fetch_valid, refill_req}, 3'b100);
    while (busy) @(negedge clk);
    do_fetch(10'd4, 4'd15, 2'd0, 8'd7, 1'b0, 1'b0, 8'd7, "R6 asid7 gone");

    // R8: invalidate-all beats ASID invalidate and fetch.
    @(negedge clk);
    inv_all_req = 1'b1; inv_asid_req = 1'b1; inv_asid_id = 8'd3;
    fetch_req = 1'b1; fetch_va = {10'd4, 4'd15, 2'd0}; fetch_asid = 8'd7;
    @(negedge clk);
    inv_all_req = 1'b0; inv_asid_req = 1'b0; fetch_req = 1'b0;
    check(!busy && !fetch_valid && !refill_req && ready, "R8 all wins",
          {busy, fetch_valid, refill_req, ready}, 4'b0001);
    // R7: everything gone, global line included.
    do_fetch(10'd4, 4'd15, 2'd0, 8'd7, 1'b0, 1'b0, 8'd7, "R7 line cleared");
    do_fetch(10'd3, 4'd7, 2'd0, 8'd2, 1'b0, 1'b0, 8'd2, "R7 global cleared");
    do_fetch(10'd3, 4'd7, 2'd1, 8'd2, 1'b0, 1'b1, 8'd2, "R2 refetch hit");

    // R7: a plain invalidate-all with no other request.
    @(negedge clk);
    inv_all_req = 1'b1;
    @(negedge clk);
    inv_all_req = 1'b0;
    check(!busy && ready, "R7 single cycle", {busy, ready}, 2'b01);
    do_fetch(10'd3, 4'd7, 2'd1, 8'd2, 1'b0, 1'b0, 8'd2, "R7 after clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule